// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single TX line. A line-control byte sets the shape of the frame. It selects a word length of 5 to 8 bits, no parity, odd or even parity, or a parity bit forced to a fixed value. It also selects one stop bit, or a longer stop period of one and a half or two bits. The block sends a start bit at 0, then the data bits least significant first, then the parity bit if one is enabled, then the stop period at 1. Between frames the line rests at 1.

Timing comes from a baud tick that runs at sixteen times the bit rate, so one bit lasts sixteen ticks and a half bit lasts eight. A host offers a byte with a valid/ready handshake. The byte is taken on a clock edge where both are high. The format is captured at that same edge, so changing the control byte during a frame does not alter that frame. A break control in the same byte drives the line to 0 whenever it is set. While break is set, a frame in progress keeps its timing but none of its bits reach the pin.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is clear, `txd` is 1, `tx_ready` is 1 and `busy` is 0.
- R2: A byte is accepted at a rising clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle `busy` is 1 and `tx_ready` is 0 until the frame ends, and `tx_valid` is ignored during that time.
- R3: A frame starts with a 0 start bit lasting 16 ticks. It is followed by the data bits, least significant bit first, each lasting 16 ticks.
- R4: `line_ctl[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length are not sent.
- R5: When `line_ctl[3]` is 1, a 16-tick parity bit follows the data bits. With `line_ctl[4]`=0 the parity bit gives an odd number of ones across the sent data bits and the parity bit. With `line_ctl[4]`=1 it gives an even number. When `line_ctl[3]` is 0, no parity bit is sent.
- R6: When `line_ctl[5]` and `line_ctl[3]` are both 1, the parity bit is forced to the inverse of `line_ctl[4]`, whatever the data. `line_ctl[5]` has no effect when `line_ctl[3]` is 0.
- R7: The stop period is 1. With `line_ctl[2]`=0 it lasts 16 ticks. With `line_ctl[2]`=1 it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. `busy` falls on the cycle after the last stop tick.
- R8: While `line_ctl[6]` is 1, `txd` is 0 in the same cycle, busy or idle. Frame timing keeps running underneath, and the line returns to the current frame bit, or to 1 if idle, as soon as the bit is cleared.
- R9: Bits 0 to 5 of `line_ctl` are captured when a byte is accepted, and changing them during the frame has no effect on that frame. `line_ctl[7]` has no effect at any time.
- R10: Frame timing advances only on cycles where `tick16` is 1. Cycles without a tick change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Baud tick at 16 times the bit rate, one cycle wide |
| line_ctl | input | 8 | Frame format and break control |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| txd | output | 1 | Serial line output |
| busy | output | 1 | Frame in progress |

## Verification
A wrong tick count or a wrong phase step shows at `txd` within one bit period. It appears as a bit edge one tick early or late, and the per-cycle comparison against a segment-list model flags it on that tick. A wrong format capture or a wrong parity decode shows as a wrong level on a single bit, or as a stop period of the wrong length. The bench covers every word length, every parity mode and every stop setting, so each decode path is exercised. Errors in break handling or in the handshake show in the same cycle, at `txd` or at `tx_ready`/`busy`, because these are compared on every clock.

// File: rtl/uft_pkg.sv
package uft_pkg;

   typedef struct packed {
      logic       spare;      // bit 7: no function in this block
      logic       brk;        // bit 6: hold line low
      logic       stick;      // bit 5: forced parity
      logic       even;       // bit 4: even parity / forced value select
      logic       par_en;     // bit 3: parity bit present
      logic       long_stop;  // bit 2: extended stop period
      logic [1:0] wlen;       // bits 1:0: word length minus five
   } ctl_t;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_DATA  = 3'd2,
      PH_PAR   = 3'd3,
      PH_STOP  = 3'd4
   } phase_t;

endpackage

// File: rtl/uft_fmt_decode.sv
module uft_fmt_decode
   import uft_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] data,
   output logic [IDX_W-1:0]  last_idx,
   output logic              par_en,
   output logic              par_bit,
   output logic [2:0]        stop_halves
);

   logic [DATA_W-1:0] mask;
   logic              ones_odd;

   assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(ctl.wlen);

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign mask[gi] = ({1'b0, last_idx} >= (IDX_W+1)'(gi));
   end

   assign ones_odd = ^(data & mask);
   assign par_en   = ctl.par_en;

   always_comb begin
      if (ctl.stick)
         par_bit = ~ctl.even;
      else if (ctl.even)
         par_bit = ones_odd;
      else
         par_bit = ~ones_odd;
   end

   always_comb begin
      if (!ctl.long_stop)
         stop_halves = 3'd2;
      else if (ctl.wlen == 2'b00)
         stop_halves = 3'd3;
      else
         stop_halves = 3'd4;
   end

endmodule

// File: rtl/uft_sequencer.sv
module uft_sequencer
   import uft_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16,
   localparam int IDX_W = $clog2(DATA_W),
   localparam int CW    = $clog2(2 * TICKS_PER_BIT),
   localparam int HALF  = TICKS_PER_BIT / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [DATA_W-1:0] data_in,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic              par_en,
   input  logic              par_bit,
   input  logic [2:0]        stop_halves,
   output logic              busy,
   output logic              line_bit,
   output logic [CW-1:0]     tick_cnt
);

   phase_t            phase;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx, last_q;
   logic              pen_q, pbit_q;
   logic [2:0]        halves_q;
   logic [CW:0]       limit;
   logic              seg_end;

   always_comb begin
      if (phase == PH_STOP)
         limit = (CW+1)'(halves_q) * (CW+1)'(HALF) - (CW+1)'(1);
      else
         limit = (CW+1)'(TICKS_PER_BIT - 1);
   end

   assign seg_end = ({1'b0, tick_cnt} == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         tick_cnt <= '0;
         idx      <= '0;
         shreg    <= '0;
         last_q   <= '0;
         pen_q    <= 1'b0;
         pbit_q   <= 1'b0;
         halves_q <= 3'd2;
      end else if (phase == PH_IDLE) begin
         if (start) begin
            phase    <= PH_START;
            tick_cnt <= '0;
            idx      <= '0;
            shreg    <= data_in;
            last_q   <= last_idx;
            pen_q    <= par_en;
            pbit_q   <= par_bit;
            halves_q <= stop_halves;
         end
      end else if (tick) begin
         if (seg_end) begin
            tick_cnt <= '0;
            unique case (phase)
               PH_START: phase <= PH_DATA;
               PH_DATA: begin
                  shreg <= shreg >> 1;
                  if (idx == last_q)
                     phase <= pen_q ? PH_PAR : PH_STOP;
                  else
                     idx <= idx + IDX_W'(1);
               end
               PH_PAR:   phase <= PH_STOP;
               default:  phase <= PH_IDLE;
            endcase
         end else begin
            tick_cnt <= tick_cnt + CW'(1);
         end
      end
   end

   always_comb begin
      unique case (phase)
         PH_START: line_bit = 1'b0;
         PH_DATA:  line_bit = shreg[0];
         PH_PAR:   line_bit = pbit_q;
         default:  line_bit = 1'b1;
      endcase
   end

   assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uft_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int MIN_W         = 5,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic [7:0]        line_ctl,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd,
   output logic              busy
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam int CW    = $clog2(2 * TICKS_PER_BIT);

   if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be even and at least 2");
   end
   if (DATA_W != MIN_W + 3) begin : g_bad_width
      $error("DATA_W must cover the four word lengths above MIN_W");
   end

   ctl_t             ctl;
   logic             ctl_unused;
   logic             accept, line_bit;
   logic [IDX_W-1:0] last_idx;
   logic             par_en, par_bit;
   logic [2:0]       stop_halves;
   logic [CW-1:0]    tick_cnt;

   assign ctl        = ctl_t'(line_ctl);
   assign ctl_unused = ctl.spare;
   assign tx_ready   = ~busy;
   assign accept     = tx_valid & tx_ready;

   uft_fmt_decode #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_dec (
      .ctl         (ctl),
      .data        (tx_data),
      .last_idx    (last_idx),
      .par_en      (par_en),
      .par_bit     (par_bit),
      .stop_halves (stop_halves)
   );

   uft_sequencer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .start       (accept),
      .data_in     (tx_data),
      .last_idx    (last_idx),
      .par_en      (par_en),
      .par_bit     (par_bit),
      .stop_halves (stop_halves),
      .busy        (busy),
      .line_bit    (line_bit),
      .tick_cnt    (tick_cnt)
   );

   assign txd = line_bit & ~ctl.brk;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
   parameter int CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick16,
   input logic          brk,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic          txd,
   input logic          busy,
   input logic [CW-1:0] tick_cnt
);

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !brk) |-> txd);                                // R1

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (busy && !tx_ready));         // R2

   AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !brk) |-> !txd);                         // R3

   AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> !txd);                                           // R8

   AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick16) |=> (busy && $stable(tick_cnt)));      // R10

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick16   (tick16),
   .brk      (line_ctl[6]),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .txd      (txd),
   .busy     (busy),
   .tick_cnt (tick_cnt)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [7:0] line_ctl = 8'h03;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_ready, txd, busy;

   int   n_run = 0, n_fail = 0, cyc = 0;
   bit   tick_hold = 1'b0;
   bit   finished = 1'b0;
   string cur_req = "R1";

   // reference model: list of line segments (level, length in ticks)
   int   seg_val[$];
   int   seg_len[$];
   bit   m_busy = 1'b0;
   int   m_rem = 0;

   always #2 clk = ~clk;

   uart_frame_tx uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctl(line_ctl),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .txd(txd), .busy(busy)
   );

   function automatic void check(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endfunction

   task automatic build_frame(input logic [7:0] c, input logic [7:0] d);
      int nb, ones, p, stp;
      nb = 5 + int'(c[1:0]);
      ones = 0;
      seg_val.push_back(0); seg_len.push_back(16);
      for (int i = 0; i < nb; i++) begin
         seg_val.push_back(int'(d[i])); seg_len.push_back(16);
         ones += int'(d[i]);
      end
      if (c[3]) begin
         if (c[5]) p = c[4] ? 0 : 1;
         else if (c[4]) p = ones % 2;
         else p = 1 - (ones % 2);
         seg_val.push_back(p); seg_len.push_back(16);
      end
      if (!c[2]) stp = 16;
      else if (nb == 5) stp = 24;
      else stp = 32;
      seg_val.push_back(1); seg_len.push_back(stp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         seg_val.delete(); seg_len.delete(); m_busy = 1'b0; m_rem = 0;
      end else if (!m_busy) begin
         if (tx_valid) begin
            build_frame(line_ctl, tx_data);
            m_busy = 1'b1;
            m_rem = seg_len[0];
         end
      end else if (tick16) begin
         m_rem--;
         if (m_rem == 0) begin
            void'(seg_val.pop_front()); void'(seg_len.pop_front());
            if (seg_val.size() == 0) m_busy = 1'b0;
            else m_rem = seg_len[0];
         end
      end
   end

   always @(negedge clk) begin
      int exp_txd;
      if (rst_n && !finished) begin
         exp_txd = line_ctl[6] ? 0 : (m_busy ? seg_val[0] : 1);
         check(cur_req, "txd", int'(txd), exp_txd);
         check(cur_req, "busy", int'(busy), int'(m_busy));
         check(cur_req, "tx_ready", int'(tx_ready), int'(!m_busy));
      end
   end

   // baud tick: every third cycle unless held off
   initial begin
      int k = 0;
      forever begin
         @(posedge clk); #1;
         k++;
         tick16 = (!tick_hold) && (k % 3 == 0);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic offer(input logic [7:0] c, input logic [7:0] d);
      while (!tx_ready) step(1);
      line_ctl = c; tx_data = d; tx_valid = 1'b1;
      step(1);
      tx_valid = 1'b0;
   endtask

   task automatic drain();
      while (m_busy || busy) step(1);
      step(2);
   endtask

   task automatic frame(string req, input logic [7:0] c, input logic [7:0] d);
      cur_req = req;
      offer(c, d);
      drain();
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset txd", int'(txd), 1);
      check("R1", "reset tx_ready", int'(tx_ready), 1);
      check("R1", "reset busy", int'(busy), 0);
      step(1);

      // R3 R4: all word lengths, no parity, one stop
      frame("R3", 8'h03, 8'hA5);
      frame("R4", 8'h00, 8'hFF);
      frame("R4", 8'h01, 8'hD6);
      frame("R4", 8'h02, 8'h3C);
      frame("R4", 8'h03, 8'h01);

      // R5: odd and even parity over several patterns and widths
      frame("R5", 8'h0B, 8'h00);
      frame("R5", 8'h0B, 8'h07);
      frame("R5", 8'h1B, 8'h07);
      frame("R5", 8'h18, 8'hE3);
      frame("R5", 8'h0A, 8'hFE);

      // R6: forced parity, and stick bit without parity enable
      frame("R6", 8'h2B, 8'h00);
      frame("R6", 8'h3B, 8'hFF);
      frame("R6", 8'h38, 8'h15);
      frame("R6", 8'h23, 8'h5A);

      // R7: stop lengths
      frame("R7", 8'h04, 8'h0A);
      frame("R7", 8'h07, 8'h96);
      frame("R7", 8'h0D, 8'h33);
      frame("R7", 8'h05, 8'h2F);

      // R2: valid held high while busy, different data offered
      cur_req = "R2";
      offer(8'h03, 8'h81);
      tx_data = 8'h7E; tx_valid = 1'b1;
      step(20);
      @(negedge clk);
      check("R2", "tx_ready mid frame", int'(tx_ready), 0);
      step(1);
      tx_valid = 1'b0;
      drain();

      // R8: break during a frame and while idle
      cur_req = "R8";
      offer(8'h0B, 8'hC3);
      step(60);
      line_ctl = 8'h4B;
      step(1);
      @(negedge clk);
      check("R8", "txd under break", int'(txd), 0);
      step(200);
      line_ctl = 8'h0B;
      drain();
      line_ctl = 8'h43;
      step(1);
      @(negedge clk);
      check("R8", "idle txd under break", int'(txd), 0);
      line_ctl = 8'h03;
      step(1);
      @(negedge clk);
      check("R8", "idle txd after break", int'(txd), 1);

      // R9: format change mid frame, spare bit set
      cur_req = "R9";
      offer(8'h07, 8'h6D);
      step(40);
      line_ctl = 8'h38;
      drain();
      frame("R9", 8'h8B, 8'h59);

      // R10: long gap without ticks in mid frame
      cur_req = "R10";
      offer(8'h1F, 8'hB2);
      step(100);
      tick_hold = 1'b1;
      step(80);
      tick_hold = 1'b0;
      drain();

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule